// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the memory address sequence for one channel of a DMA engine. A start pulse captures a descriptor: the start address, an element count per row, a signed step between elements, a row count, a signed step between rows, and a set of mode bits. After that, each element that the data path accepts moves the address and the counters forward by one step. The bus data path itself sits outside the block. It only reports that an element was accepted and reads back the address to use for the next element.

The block can walk a single row or a grid of rows. At the last element of a row it does one of three things. It can start the next row by adding the row step in place of the element step. It can stop with a done flag. Or it can hold a request for the descriptor loader to supply the next descriptor, which the loader delivers by pulsing start again. It can also raise a one-cycle interrupt, either at every row end or only at the end of the work unit. A direction bit is captured with the descriptor and passed out, so the data path knows whether memory is written or read.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset the address, both counts, the interrupt, the reload request, the done flag, the busy flag and the direction output are all zero.
- R2: A start pulse loads the address from the start address and both counts from their configured values, with a configured count of 0 loading 65536. It sets busy, clears done and clears the reload request, all visible one cycle later.
- R3: An accepted element that is not the last of its row adds the sign-extended element step to the address modulo 2^32 and decrements the X count by one.
- R4: In 2D mode (two_dim = 1), the last element of a row with a Y count above 1 decrements the Y count and reloads the X count from its configured value (0 meaning 65536). It adds the sign-extended row step to the address and does not apply the element step.
- R5: The last element of the work unit adds the element step, leaves the X count at 0 and clears busy. With flow code 0 (stop) it sets done; with any other flow code (1, 2 or 3) it sets the reload request.
- R6: With the interrupt enable set, irq is high for exactly the one cycle after a qualifying row end. With row mode set, every row end qualifies; with row mode clear, only the end of the work unit does. With the enable clear, irq stays low.
- R7: elem_ack has no effect on any output while busy is low: before the first start, after done, and while the reload request is pending.
- R8: In 1D mode (two_dim = 0) the configured Y count does not affect the walk. The first row end is the end of the work unit, and the Y count output keeps its loaded value.
- R9: mem_write shows the direction bit captured at the last start (1 = peripheral to memory, 0 = memory to peripheral) and does not follow later changes to the input.
- R10: A start pulse while the reload request is pending clears the request and begins the new descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture the descriptor inputs and begin a work unit |
| elem_ack | input | 1 | One element accepted by the data path |
| cfg_addr | input | 32 | Start address |
| cfg_x_count | input | 16 | Elements per row (0 = 65536) |
| cfg_x_step | input | 16 | Signed address step between elements |
| cfg_y_count | input | 16 | Rows per work unit in 2D mode (0 = 65536) |
| cfg_y_step | input | 16 | Signed address step from the last element of a row to the first of the next |
| cfg_two_dim | input | 1 | 1 = 2D walk, 0 = 1D walk |
| cfg_flow | input | 2 | 0 = stop at the end, other codes = request the next descriptor |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_irq_row | input | 1 | 1 = interrupt at every row end, 0 = only at the end of the work unit |
| cfg_dir | input | 1 | 1 = peripheral to memory, 0 = memory to peripheral |
| cur_addr | output | 32 | Address of the next element |
| cur_x | output | 17 | Remaining elements in the current row |
| cur_y | output | 17 | Remaining rows, counting the current one |
| irq | output | 1 | One-cycle interrupt pulse |
| reload_req | output | 1 | Next descriptor wanted, held until start |
| done | output | 1 | Work unit finished in stop flow, held until start |
| busy | output | 1 | Elements are being accepted |
| mem_write | output | 1 | Captured direction bit |

## Verification
The assertions check on every cycle that done and the reload request are never high together. They check that busy always comes with nonzero counts, that the address and counts hold still whenever the block is idle and no start arrives, and that an interrupt only follows an accepted element. Only the bench scenarios show the actual address arithmetic: steps that wrap, a row step used in place of the element step, and a count of zero loading 65536. The same holds for the choice between done and reload for each flow code, the difference between row and unit interrupts, and 1D mode leaving the Y count alone.

// File: rtl/dag_pkg.sv
package dag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_RELOAD = 2'd2,
        ST_DONE   = 2'd3
    } dag_state_e;

    typedef enum logic [1:0] {
        FLOW_STOP  = 2'd0,
        FLOW_AUTO  = 2'd1,
        FLOW_ARRAY = 2'd2,
        FLOW_LIST  = 2'd3
    } dag_flow_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_STEP = 2'd1,
        EV_ROW  = 2'd2,
        EV_END  = 2'd3
    } dag_event_e;

    typedef struct packed {
        logic      two_dim;
        dag_flow_e flow;
        logic      irq_en;
        logic      irq_row;
        logic      mem_wr;
    } dag_mode_t;

endpackage

// File: rtl/dag_count.sv
module dag_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             reload,
    input  logic             dec,
    output logic [CNT_W:0]   cur,
    output logic             is_one,
    output logic             gt_one
);
    localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};
    localparam logic [CNT_W:0] ONE  = {{CNT_W{1'b0}}, 1'b1};

    logic [CNT_W:0] base_q;
    logic [CNT_W:0] load_exp;

    always_comb begin
        if (load_val == '0)
            load_exp = FULL;
        else
            load_exp = {1'b0, load_val};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur    <= '0;
        end else if (load) begin
            base_q <= load_exp;
            cur    <= load_exp;
        end else if (reload) begin
            cur    <= base_q;
        end else if (dec) begin
            cur    <= cur - ONE;
        end
    end

    assign is_one = (cur == ONE);
    assign gt_one = (cur > ONE);
endmodule

// File: rtl/dag_addr.sv
module dag_addr #(
    parameter int ADDR_W = 32,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [STEP_W-1:0] x_step_in,
    input  logic [STEP_W-1:0] y_step_in,
    input  dag_pkg::dag_event_e ev,
    output logic [ADDR_W-1:0] addr
);
    import dag_pkg::*;

    localparam int EXT_W = ADDR_W - STEP_W;

    logic [STEP_W-1:0] x_step_q;
    logic [STEP_W-1:0] y_step_q;
    logic [ADDR_W-1:0] x_ext;
    logic [ADDR_W-1:0] y_ext;
    logic [ADDR_W-1:0] addr_nxt;

    assign x_ext = {{EXT_W{x_step_q[STEP_W-1]}}, x_step_q};
    assign y_ext = {{EXT_W{y_step_q[STEP_W-1]}}, y_step_q};

    always_comb begin
        unique case (ev)
            EV_STEP, EV_END: addr_nxt = addr + x_ext;
            EV_ROW:          addr_nxt = addr + y_ext;
            default:         addr_nxt = addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr     <= '0;
            x_step_q <= '0;
            y_step_q <= '0;
        end else if (load) begin
            addr     <= load_addr;
            x_step_q <= x_step_in;
            y_step_q <= y_step_in;
        end else begin
            addr     <= addr_nxt;
        end
    end
endmodule

// File: rtl/dag_ctrl.sv
module dag_ctrl (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                elem_ack,
    input  dag_pkg::dag_mode_t  mode_in,
    input  logic                x_last,
    input  logic                y_more,
    output dag_pkg::dag_event_e ev,
    output logic                irq,
    output logic                busy,
    output logic                done,
    output logic                reload_req,
    output logic                mem_write
);
    import dag_pkg::*;

    dag_state_e state_q;
    dag_state_e state_nxt;
    dag_mode_t  mode_q;
    logic       accept;
    logic       irq_nxt;

    assign accept = elem_ack && (state_q == ST_RUN) && !start;

    always_comb begin
        if (!accept)
            ev = EV_NONE;
        else if (!x_last)
            ev = EV_STEP;
        else if (mode_q.two_dim && y_more)
            ev = EV_ROW;
        else
            ev = EV_END;
    end

    always_comb begin
        state_nxt = state_q;
        if (start)
            state_nxt = ST_RUN;
        else if (ev == EV_END)
            state_nxt = (mode_q.flow == FLOW_STOP) ? ST_DONE : ST_RELOAD;
    end

    assign irq_nxt = mode_q.irq_en &&
                     ((ev == EV_END) || ((ev == EV_ROW) && mode_q.irq_row));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            irq     <= 1'b0;
        end else begin
            state_q <= state_nxt;
            irq     <= irq_nxt && !start;
            if (start)
                mode_q <= mode_in;
        end
    end

    assign busy       = (state_q == ST_RUN);
    assign done       = (state_q == ST_DONE);
    assign reload_req = (state_q == ST_RELOAD);
    assign mem_write  = mode_q.mem_wr;
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              elem_ack,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_x_count,
    input  logic [CNT_W-1:0]  cfg_x_step,
    input  logic [CNT_W-1:0]  cfg_y_count,
    input  logic [CNT_W-1:0]  cfg_y_step,
    input  logic              cfg_two_dim,
    input  logic [1:0]        cfg_flow,
    input  logic              cfg_irq_en,
    input  logic              cfg_irq_row,
    input  logic              cfg_dir,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W:0]    cur_x,
    output logic [CNT_W:0]    cur_y,
    output logic              irq,
    output logic              reload_req,
    output logic              done,
    output logic              busy,
    output logic              mem_write
);
    import dag_pkg::*;

    dag_mode_t  mode_in;
    dag_event_e ev;
    logic       x_last;
    logic       x_gt_one;
    logic       y_one;
    logic       y_more;

    always_comb begin
        mode_in.two_dim = cfg_two_dim;
        mode_in.flow    = dag_flow_e'(cfg_flow);
        mode_in.irq_en  = cfg_irq_en;
        mode_in.irq_row = cfg_irq_row;
        mode_in.mem_wr  = cfg_dir;
    end

    dag_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .elem_ack   (elem_ack),
        .mode_in    (mode_in),
        .x_last     (x_last),
        .y_more     (y_more),
        .ev         (ev),
        .irq        (irq),
        .busy       (busy),
        .done       (done),
        .reload_req (reload_req),
        .mem_write  (mem_write)
    );

    dag_count #(.CNT_W(CNT_W)) u_xcnt (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (cfg_x_count),
        .reload   (ev == EV_ROW),
        .dec      ((ev == EV_STEP) || (ev == EV_END)),
        .cur      (cur_x),
        .is_one   (x_last),
        .gt_one   (x_gt_one)
    );

    dag_count #(.CNT_W(CNT_W)) u_ycnt (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (cfg_y_count),
        .reload   (1'b0),
        .dec      (ev == EV_ROW),
        .cur      (cur_y),
        .is_one   (y_one),
        .gt_one   (y_more)
    );

    dag_addr #(.ADDR_W(ADDR_W), .STEP_W(CNT_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .load_addr (cfg_addr),
        .x_step_in (cfg_x_step),
        .y_step_in (cfg_y_step),
        .ev        (ev),
        .addr      (cur_addr)
    );

    logic unused_ok;
    assign unused_ok = x_gt_one ^ y_one;
endmodule

// File: rtl/dma2d_addr_gen_checks.sv
module dma2d_addr_gen_checks #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              elem_ack,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [CNT_W:0]    cur_x,
    input logic [CNT_W:0]    cur_y,
    input logic              irq,
    input logic              reload_req,
    input logic              done,
    input logic              busy
);
    a_r5_done_reload_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && reload_req));

    a_r2_start_begins: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && !done && !reload_req));

    a_r3_busy_counts_nonzero: assert property (@(posedge clk) disable iff (rst)
        busy |-> ((cur_x != '0) && (cur_y != '0)));

    a_r7_idle_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(cur_addr) && $stable(cur_x) && $stable(cur_y)));

    a_r6_irq_after_accept: assert property (@(posedge clk) disable iff (rst)
        (busy && !(elem_ack && !start)) |=> !irq);
endmodule

bind dma2d_addr_gen dma2d_addr_gen_checks #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_checks (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .elem_ack   (elem_ack),
    .cur_addr   (cur_addr),
    .cur_x      (cur_x),
    .cur_y      (cur_y),
    .irq        (irq),
    .reload_req (reload_req),
    .done       (done),
    .busy       (busy)
);

// File: tb/test_dma2d_addr_gen.sv
`timescale 1ns/1ps
module test_dma2d_addr_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        elem_ack = 1'b0;
    logic [31:0] cfg_addr = '0;
    logic [15:0] cfg_x_count = '0;
    logic [15:0] cfg_x_step = '0;
    logic [15:0] cfg_y_count = '0;
    logic [15:0] cfg_y_step = '0;
    logic        cfg_two_dim = 1'b0;
    logic [1:0]  cfg_flow = '0;
    logic        cfg_irq_en = 1'b0;
    logic        cfg_irq_row = 1'b0;
    logic        cfg_dir = 1'b0;
    logic [31:0] cur_addr;
    logic [16:0] cur_x;
    logic [16:0] cur_y;
    logic        irq, reload_req, done, busy, mem_write;

    int tests = 0;
    int fails = 0;

    // reference state
    logic [31:0] m_addr;
    logic [16:0] m_x, m_y, m_xbase;
    logic [31:0] m_xs, m_ys;
    logic        m_2d, m_en, m_row, m_dir, m_irq, m_busy, m_done, m_rel;
    logic [1:0]  m_flow;

    always #2.5 clk = ~clk;

    dma2d_addr_gen i_dma2d_addr_gen (
        .clk(clk), .rst(rst), .start(start), .elem_ack(elem_ack),
        .cfg_addr(cfg_addr), .cfg_x_count(cfg_x_count), .cfg_x_step(cfg_x_step),
        .cfg_y_count(cfg_y_count), .cfg_y_step(cfg_y_step), .cfg_two_dim(cfg_two_dim),
        .cfg_flow(cfg_flow), .cfg_irq_en(cfg_irq_en), .cfg_irq_row(cfg_irq_row),
        .cfg_dir(cfg_dir), .cur_addr(cur_addr), .cur_x(cur_x), .cur_y(cur_y),
        .irq(irq), .reload_req(reload_req), .done(done), .busy(busy),
        .mem_write(mem_write)
    );

    function automatic logic [16:0] expand(input logic [15:0] v);
        return (v == 16'd0) ? 17'h10000 : {1'b0, v};
    endfunction

    function automatic logic [31:0] sext(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_addr = '0; m_x = '0; m_y = '0; m_xbase = '0; m_xs = '0; m_ys = '0;
        m_2d = 0; m_en = 0; m_row = 0; m_dir = 0; m_irq = 0;
        m_busy = 0; m_done = 0; m_rel = 0; m_flow = '0;
    endtask

    task automatic model_step();
        if (start) begin
            m_addr = cfg_addr; m_xbase = expand(cfg_x_count); m_x = m_xbase;
            m_y = expand(cfg_y_count); m_xs = sext(cfg_x_step); m_ys = sext(cfg_y_step);
            m_2d = cfg_two_dim; m_flow = cfg_flow; m_en = cfg_irq_en;
            m_row = cfg_irq_row; m_dir = cfg_dir;
            m_busy = 1; m_done = 0; m_rel = 0; m_irq = 0;
        end else if (elem_ack && m_busy) begin
            m_irq = 0;
            if (m_x > 17'd1) begin
                m_addr = m_addr + m_xs; m_x = m_x - 17'd1;
            end else if (m_2d && m_y > 17'd1) begin
                m_y = m_y - 17'd1; m_x = m_xbase; m_addr = m_addr + m_ys;
                m_irq = m_en && m_row;
            end else begin
                m_addr = m_addr + m_xs; m_x = 17'd0; m_busy = 0;
                if (m_flow == 2'd0) m_done = 1; else m_rel = 1;
                m_irq = m_en;
            end
        end else begin
            m_irq = 0;
        end
    endtask

    task automatic compare_all(input string req);
        chk(req, "cur_addr", cur_addr, m_addr);
        chk(req, "cur_x", {15'd0, cur_x}, {15'd0, m_x});
        chk(req, "cur_y", {15'd0, cur_y}, {15'd0, m_y});
        chk(req, "irq", {31'd0, irq}, {31'd0, m_irq});
        chk(req, "done", {31'd0, done}, {31'd0, m_done});
        chk(req, "reload_req", {31'd0, reload_req}, {31'd0, m_rel});
        chk(req, "busy", {31'd0, busy}, {31'd0, m_busy});
        chk(req, "mem_write", {31'd0, mem_write}, {31'd0, m_dir});
    endtask

    // drive at the falling edge, check at the next falling edge
    task automatic cyc(input logic st, input logic ack, input string req);
        start = st; elem_ack = ack;
        model_step();
        @(negedge clk);
        start = 0; elem_ack = 0;
        compare_all(req);
    endtask

    task automatic set_cfg(input logic [31:0] a, input logic [15:0] xc, input logic [15:0] xs,
                           input logic [15:0] yc, input logic [15:0] ys, input logic td,
                           input logic [1:0] fl, input logic en, input logic row, input logic dr);
        cfg_addr = a; cfg_x_count = xc; cfg_x_step = xs; cfg_y_count = yc;
        cfg_y_step = ys; cfg_two_dim = td; cfg_flow = fl; cfg_irq_en = en;
        cfg_irq_row = row; cfg_dir = dr;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        compare_all("R1");

        // R7: ack before any start does nothing
        cyc(0, 1, "R7");

        // R2: zero counts load 65536
        set_cfg(32'h1000_0000, 16'd0, 16'd4, 16'd0, 16'd8, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1);
        cyc(1, 0, "R2");
        chk("R2", "cur_x zero->65536", {15'd0, cur_x}, 32'h10000);

        // R3: wrap at the top of the address space, negative step
        set_cfg(32'hFFFF_FFFC, 16'd3, 16'd4, 16'd1, 16'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        cyc(1, 0, "R3");
        cyc(0, 1, "R3");
        chk("R3", "wrapped addr", cur_addr, 32'h0000_0000);
        set_cfg(32'h0000_0002, 16'd3, 16'hFFFC, 16'd1, 16'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        cyc(1, 0, "R3");
        cyc(0, 1, "R3");
        chk("R3", "neg wrap addr", cur_addr, 32'hFFFF_FFFE);

        // R4 + R6 row interrupts: 2 x 3 grid
        set_cfg(32'h0000_1000, 16'd2, 16'd4, 16'd3, 16'h0100, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0);
        cyc(1, 0, "R4");
        cyc(0, 1, "R4");
        cyc(0, 1, "R4");
        chk("R4", "row step addr", cur_addr, 32'h0000_1104);
        chk("R6", "row irq", {31'd0, irq}, 32'd1);
        cyc(0, 0, "R6");
        chk("R6", "irq one cycle", {31'd0, irq}, 32'd0);
        repeat (4) cyc(0, 1, "R5");
        chk("R5", "done after grid", {31'd0, done}, 32'd1);
        // R7: ack after done
        cyc(0, 1, "R7");
        chk("R7", "addr held after done", cur_addr, 32'h0000_1210);

        // R8: 1D with Y count 5
        set_cfg(32'h0000_2000, 16'd2, 16'd1, 16'd5, 16'h0040, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1);
        cyc(1, 0, "R8");
        cyc(0, 1, "R8");
        cyc(0, 1, "R8");
        chk("R8", "unit ends in 1D", {31'd0, done}, 32'd1);
        chk("R8", "cur_y untouched", {15'd0, cur_y}, 32'd5);
        chk("R6", "unit irq", {31'd0, irq}, 32'd1);

        // R9: direction latched
        cfg_dir = 1'b0;
        cyc(0, 0, "R9");
        chk("R9", "mem_write latched", {31'd0, mem_write}, 32'd1);

        // R10: reload flow, ack while pending, restart
        set_cfg(32'h0000_3000, 16'd1, 16'd2, 16'd1, 16'd0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0);
        cyc(1, 0, "R10");
        cyc(0, 1, "R5");
        chk("R5", "reload request", {31'd0, reload_req}, 32'd1);
        cyc(0, 1, "R7");
        chk("R7", "addr held in reload", cur_addr, 32'h0000_3002);
        set_cfg(32'h0000_4000, 16'd2, 16'd2, 16'd1, 16'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        cyc(1, 0, "R10");
        chk("R10", "request cleared", {31'd0, reload_req}, 32'd0);

        // random phase covering R3 R4 R5 R6 R9
        for (int d = 0; d < 120; d++) begin
            set_cfg($urandom(), 16'($urandom_range(0, 4) == 0 ? 1 : $urandom_range(1, 4)),
                    16'($urandom()), 16'($urandom_range(1, 3)), 16'($urandom()),
                    1'($urandom()), 2'($urandom()), 1'($urandom()), 1'($urandom()),
                    1'($urandom()));
            cyc(1, 0, "R2");
            for (int c = 0; c < 24; c++)
                cyc(1'b0, ($urandom_range(0, 9) < 7), "R3/R4/R5/R6");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule